// File: doc/BRIEF.md
# Event-Qualified Processor Trace Buffer

This block sits beside a small soft processor and keeps a compact history of what the processor did. A record is not taken on every cycle. One is taken only when a qualifying event happens. A register-file write stores the destination register number and the value written. A taken branch stores the program counter. The register file as a whole is never sampled: only the register being written is recorded. Records go into a circular dual-port memory. The capture side owns the write port, and the read-back side owns the other port.

Events arrive on a valid/ready stream. `ev_ready` is a registered output. The producer presents `rf_we` and/or `br_taken` only when `ev_ready` is high, and holds both low while it is low. When both events qualify in the same cycle, the register-write record is stored that cycle. The branch record waits one cycle in a single-entry skid register, and `ev_ready` is low for that cycle.

A trigger input marks the fault. Capture then continues for a programmable number of further records, stops, and raises `done`. The stored history is then streamed out oldest-first on a valid/ready read port. `rd_data` and `rd_valid` hold while `rd_ready` is low. `rd_last` flags the final record. A synchronous clear re-arms the unit.

Top module: `evq_trace_top`

## Requirements
- R1: A register write (`rf_we`) is stored as a record with bit 37 = 0, bits 36:32 = `rf_addr` and bits 31:0 = `rf_wdata`.
- R2: A taken branch (`br_taken`) is stored as a record with bit 37 = 1, bits 36:32 = 0 and bits 31:0 = `br_pc`.
- R3: When `rf_we` and `br_taken` are accepted in the same cycle, the register record is stored before the branch record. `ev_ready` is low in the cycle after that acceptance and high again the cycle after.
- R4: The buffer holds 16 records by default. When more than 16 records are stored before capture stops, only the 16 most recent remain readable.
- R5: A trigger received while armed lets exactly `post_cnt` further records be stored. `done` then rises in the cycle after the edge that stores the last of them.
- R6: With `post_cnt` = 0, capture stops at the trigger. The record stored in the trigger cycle, if any, is the last one kept.
- R7: Events offered while `done` is high are not stored, and `done` stays high until a clear.
- R8: After `done`, the read port delivers every kept record exactly once, oldest first, with `rd_last` high on the final one. `rd_valid` and `rd_data` stay unchanged while `rd_ready` is low, and `rd_valid` is low once the last record has been taken.
- R9: A one-cycle `clr` pulse drops `done` and `rd_valid`, empties the buffer and re-arms capture.
- R10: After reset, `done` and `rd_valid` are low and `ev_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear and re-arm |
| rf_we | input | 1 | Register-write event valid |
| rf_addr | input | 5 | Destination register number |
| rf_wdata | input | 32 | Value written to the register |
| br_taken | input | 1 | Taken-branch event valid |
| br_pc | input | 32 | Branch program counter |
| ev_ready | output | 1 | Event stream ready |
| trig | input | 1 | Fault trigger |
| post_cnt | input | 8 | Records to keep after the trigger |
| done | output | 1 | Capture stopped |
| rd_valid | output | 1 | Read-back record valid |
| rd_ready | input | 1 | Read-back consumer ready |
| rd_data | output | 38 | Read-back record |
| rd_last | output | 1 | Final record of the history |

## Verification
Records are stored at the edge that accepts the event. A deferred branch record is stored one edge later, and `ev_ready` reads low in exactly that intervening cycle, so the bench drives events only when it samples `ev_ready` high at the falling edge. `done` is due one cycle after the final counted record is stored, and the first read-back record appears two cycles after `done`. The bench therefore polls `done` and `rd_valid` at falling edges rather than assuming a fixed delay. A transfer is scored at the falling edge before the rising edge that takes it, using the `rd_ready` value just driven. Expected records come from a bench list of every accepted event, truncated at the trigger point plus `post_cnt` and cut to the last 16.

// File: rtl/evq_pkg.sv
package evq_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_POST  = 2'd1,
    ST_STOP  = 2'd2
  } cap_state_e;

  localparam logic TAG_REG = 1'b0;
  localparam logic TAG_BR  = 1'b1;
endpackage

// File: rtl/evq_qualify.sv
module evq_qualify #(
  parameter int RA_W = 5,
  parameter int DW   = 32,
  localparam int REC_W = 1 + RA_W + DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             enable,
  input  logic             rf_we,
  input  logic [RA_W-1:0]  rf_addr,
  input  logic [DW-1:0]    rf_wdata,
  input  logic             br_taken,
  input  logic [DW-1:0]    br_pc,
  output logic             ev_ready,
  output logic             wr_en,
  output logic [REC_W-1:0] wr_rec
);
  import evq_pkg::*;

  logic             skid_v;
  logic [REC_W-1:0] skid_rec;
  logic [REC_W-1:0] reg_rec, br_rec;
  logic             raw_en;

  assign reg_rec  = {TAG_REG, rf_addr, rf_wdata};
  assign br_rec   = {TAG_BR, {RA_W{1'b0}}, br_pc};
  assign ev_ready = !skid_v;

  always_comb begin
    raw_en = 1'b0;
    wr_rec = reg_rec;
    if (skid_v) begin
      raw_en = 1'b1;
      wr_rec = skid_rec;
    end else if (rf_we) begin
      raw_en = 1'b1;
      wr_rec = reg_rec;
    end else if (br_taken) begin
      raw_en = 1'b1;
      wr_rec = br_rec;
    end
  end

  assign wr_en = raw_en && enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skid_v   <= 1'b0;
      skid_rec <= '0;
    end else if (clr || !enable || skid_v) begin
      skid_v <= 1'b0;
    end else if (rf_we && br_taken) begin
      skid_v   <= 1'b1;
      skid_rec <= br_rec;
    end
  end

  p_skid_drains_r3: assert property (@(posedge clk) disable iff (!rst_n)
    skid_v |=> !skid_v);

  p_ready_low_after_dual_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !clr && ev_ready && rf_we && br_taken) |=> !ev_ready);
endmodule

// File: rtl/evq_ctrl.sv
module evq_ctrl #(
  parameter int AW     = 4,
  parameter int POST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              trig,
  input  logic [POST_W-1:0] post_cnt,
  input  logic              wr_en,
  output logic              enable,
  output logic [AW-1:0]     wptr,
  output logic              wrapped,
  output logic              done
);
  import evq_pkg::*;

  localparam int DEPTH = 1 << AW;

  cap_state_e        state;
  logic [POST_W-1:0] left;

  assign enable = (state != ST_STOP);
  assign done   = (state == ST_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_ARMED;
      left    <= '0;
      wptr    <= '0;
      wrapped <= 1'b0;
    end else if (clr) begin
      state   <= ST_ARMED;
      left    <= '0;
      wptr    <= '0;
      wrapped <= 1'b0;
    end else begin
      if (wr_en) begin
        wptr <= wptr + 1'b1;
        if (wptr == AW'(DEPTH - 1)) wrapped <= 1'b1;
      end
      unique case (state)
        ST_ARMED: if (trig) begin
          if (post_cnt == '0) state <= ST_STOP;
          else begin
            state <= ST_POST;
            left  <= post_cnt;
          end
        end
        ST_POST: if (wr_en) begin
          if (left == POST_W'(1)) state <= ST_STOP;
          left <= left - 1'b1;
        end
        default: state <= ST_STOP;
      endcase
    end
  end

  p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && wptr == AW'(DEPTH - 1)) |=> (wptr == '0 && wrapped));

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> done);

  p_no_write_when_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);

  p_zero_post_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && trig && !clr && post_cnt == '0) |=> done);
endmodule

// File: rtl/evq_ram.sv
module evq_ram #(
  parameter int AW = 4,
  parameter int W  = 38
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/evq_reader.sv
module evq_reader #(
  parameter int AW = 4,
  parameter int W  = 38
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          done,
  input  logic [AW-1:0] wptr,
  input  logic          wrapped,
  output logic [AW-1:0] ram_addr,
  input  logic [W-1:0]  ram_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [W-1:0]  rd_data,
  output logic          rd_last
);
  localparam int DEPTH = 1 << AW;

  logic          done_q;
  logic [AW-1:0] rptr;
  logic [AW:0]   remain;

  assign ram_addr = rptr;
  assign rd_last  = rd_valid && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      rptr     <= '0;
      remain   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (clr) begin
      done_q   <= 1'b0;
      rptr     <= '0;
      remain   <= '0;
      rd_valid <= 1'b0;
    end else begin
      done_q <= done;
      if (done && !done_q) begin
        rptr   <= wrapped ? wptr : '0;
        remain <= wrapped ? (AW+1)'(DEPTH) : {1'b0, wptr};
      end else if ((!rd_valid || rd_ready) && remain != '0) begin
        rd_data  <= ram_data;
        rd_valid <= 1'b1;
        rptr     <= rptr + 1'b1;
        remain   <= remain - 1'b1;
      end else if (rd_ready) begin
        rd_valid <= 1'b0;
      end
    end
  end

  p_hold_when_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !clr) |=> (rd_valid && $stable(rd_data)));

  p_quiet_until_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !rd_valid);
endmodule

// File: rtl/evq_trace_top.sv
module evq_trace_top #(
  parameter int AW     = 4,
  parameter int RA_W   = 5,
  parameter int DW     = 32,
  parameter int POST_W = 8,
  localparam int REC_W = 1 + RA_W + DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rf_we,
  input  logic [RA_W-1:0]   rf_addr,
  input  logic [DW-1:0]     rf_wdata,
  input  logic              br_taken,
  input  logic [DW-1:0]     br_pc,
  output logic              ev_ready,
  input  logic              trig,
  input  logic [POST_W-1:0] post_cnt,
  output logic              done,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [REC_W-1:0]  rd_data,
  output logic              rd_last
);
  logic             enable, wr_en, wrapped;
  logic [REC_W-1:0] wr_rec, ram_q;
  logic [AW-1:0]    wptr, raddr;

  evq_qualify #(.RA_W(RA_W), .DW(DW)) qual_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .enable(enable),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
    .br_taken(br_taken), .br_pc(br_pc), .ev_ready(ev_ready),
    .wr_en(wr_en), .wr_rec(wr_rec));

  evq_ctrl #(.AW(AW), .POST_W(POST_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .trig(trig), .post_cnt(post_cnt),
    .wr_en(wr_en), .enable(enable), .wptr(wptr), .wrapped(wrapped),
    .done(done));

  evq_ram #(.AW(AW), .W(REC_W)) ram_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wptr), .wr_data(wr_rec),
    .rd_addr(raddr), .rd_data(ram_q));

  evq_reader #(.AW(AW), .W(REC_W)) rdr_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .done(done), .wptr(wptr),
    .wrapped(wrapped), .ram_addr(raddr), .ram_data(ram_q),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_last(rd_last));
endmodule

// File: tb/evq_trace_top_tb_top.sv
module evq_trace_top_tb_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        rf_we = 1'b0;
  logic [4:0]  rf_addr = '0;
  logic [31:0] rf_wdata = '0;
  logic        br_taken = 1'b0;
  logic [31:0] br_pc = '0;
  logic        ev_ready;
  logic        trig = 1'b0;
  logic [7:0]  post_cnt = '0;
  logic        done;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [37:0] rd_data;
  logic        rd_last;

  int checks = 0;
  int errors = 0;
  logic [37:0] gen_q[$];
  logic [37:0] exp_q[$];

  always #4 clk = ~clk;

  evq_trace_top dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .rf_we(rf_we), .rf_addr(rf_addr),
    .rf_wdata(rf_wdata), .br_taken(br_taken), .br_pc(br_pc),
    .ev_ready(ev_ready), .trig(trig), .post_cnt(post_cnt), .done(done),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_last(rd_last));

  function automatic logic [37:0] mk_reg(logic [4:0] a, logic [31:0] d);
    return {1'b0, a, d};
  endfunction

  function automatic logic [37:0] mk_br(logic [31:0] pc);
    return {1'b1, 5'd0, pc};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    rf_we = 1'b0;
    br_taken = 1'b0;
  endtask

  task automatic drive_rand();
    bit r, b;
    r = ($urandom % 3) != 0;
    b = ($urandom % 3) == 0;
    if (!ev_ready) begin r = 0; b = 0; end
    rf_we = r;
    br_taken = b;
    rf_addr = 5'($urandom);
    rf_wdata = $urandom;
    br_pc = $urandom & 32'hFFFF_FFFC;
    if (r) gen_q.push_back(mk_reg(rf_addr, rf_wdata));
    if (b) gen_q.push_back(mk_br(br_pc));
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    idle();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic read_back(string req);
    int k = 0;
    int guard = 0;
    while (k < exp_q.size() && guard < 2000) begin
      @(negedge clk);
      guard++;
      rd_ready = ($urandom % 4) != 0;
      if (rd_valid && rd_ready) begin
        chk(rd_data == exp_q[k], req, "read-back record", 64'(rd_data), 64'(exp_q[k]));
        chk(rd_last == (k == exp_q.size() - 1), "R8", "rd_last flag", 64'(rd_last),
            64'(k == exp_q.size() - 1));
        k++;
      end
    end
    chk(k == exp_q.size(), "R8", "records delivered", 64'(k), 64'(exp_q.size()));
    @(negedge clk);
    rd_ready = 1'b1;
    @(negedge clk);
    chk(rd_valid == 1'b0, "R8", "rd_valid after drain", 64'(rd_valid), 64'd0);
    rd_ready = 1'b0;
  endtask

  task automatic run_capture(int n_pre, int post, string req);
    int pre_n, keep, first, guard;
    pulse_clr();
    chk(done == 1'b0 && rd_valid == 1'b0, "R9", "re-armed after clr", 64'({done, rd_valid}), 64'd0);
    gen_q.delete();
    exp_q.delete();
    post_cnt = 8'(post);
    for (int i = 0; i < n_pre; i++) begin
      @(negedge clk);
      drive_rand();
    end
    @(negedge clk);
    idle();
    trig = 1'b1;
    pre_n = gen_q.size();
    @(negedge clk);
    trig = 1'b0;
    guard = 0;
    while (!done && guard < 2000) begin
      drive_rand();
      @(negedge clk);
      guard++;
    end
    chk(done == 1'b1, "R5", "done after post-trigger records", 64'(done), 64'd1);
    // R7: events offered while stopped must not be stored
    for (int i = 0; i < 6; i++) begin
      rf_we = 1'b1; br_taken = 1'b1;
      rf_addr = 5'd31; rf_wdata = 32'hDEAD_0000 + 32'(i); br_pc = 32'hBAD0_0000;
      @(negedge clk);
      chk(done == 1'b1, "R7", "done stays high", 64'(done), 64'd1);
    end
    idle();
    keep = pre_n + post;
    if (keep > gen_q.size()) keep = gen_q.size();
    first = (keep > DEPTH) ? keep - DEPTH : 0;
    for (int i = first; i < keep; i++) exp_q.push_back(gen_q[i]);
    read_back(req);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R10", "done after reset", 64'(done), 64'd0);
    chk(rd_valid == 1'b0, "R10", "rd_valid after reset", 64'(rd_valid), 64'd0);
    chk(ev_ready == 1'b1, "R10", "ev_ready after reset", 64'(ev_ready), 64'd1);

    // R3 directed: dual event ordering and one-cycle back-pressure
    pulse_clr();
    rf_we = 1'b1; rf_addr = 5'd9; rf_wdata = 32'h1111_2222;
    br_taken = 1'b1; br_pc = 32'h0000_4440;
    @(negedge clk);
    idle();
    chk(ev_ready == 1'b0, "R3", "ev_ready low after dual", 64'(ev_ready), 64'd0);
    @(negedge clk);
    chk(ev_ready == 1'b1, "R3", "ev_ready back high", 64'(ev_ready), 64'd1);
    post_cnt = 8'd0;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk(done == 1'b1, "R6", "stop at trigger", 64'(done), 64'd1);
    exp_q.delete();
    exp_q.push_back(mk_reg(5'd9, 32'h1111_2222));
    exp_q.push_back(mk_br(32'h0000_4440));
    read_back("R3");

    // R9: clear in mid-capture leaves nothing readable
    pulse_clr();
    for (int i = 0; i < 5; i++) begin @(negedge clk); drive_rand(); end
    pulse_clr();
    chk(done == 1'b0, "R9", "done low after mid clear", 64'(done), 64'd0);
    @(negedge clk);
    post_cnt = 8'd0; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    repeat (4) @(negedge clk);
    chk(rd_valid == 1'b0, "R9", "empty buffer after clear", 64'(rd_valid), 64'd0);

    run_capture(8, 3, "R1");
    run_capture(40, 5, "R4");
    run_capture(6, 0, "R6");
    run_capture(12, 20, "R5");
    run_capture(3, 2, "R2");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule